// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small one-address processor built around a single accumulator. Every instruction is carried out as a chain of register transfers. The transfers pass through a program counter, a memory address register, a memory data register, an instruction register and the accumulator. Each chain ends in one shared fetch state. An instruction word holds a 4-bit opcode in its upper bits and an address or device number in its lower `ADDR_W` bits. Data words have the same width as instructions and are two's complement.

The core drives a synchronous, word-addressed memory. An address presented in one cycle returns its word on the read-data input in the next cycle. A write happens while write-enable is high.

A device port serves the input and output instructions:
- An input instruction raises a request and waits for an acknowledge that carries the data.
- An output instruction raises valid with the accumulator value and waits for ready.

A halted output reports that execution has stopped for good.

Top module: `acc_core`

## Requirements
- R1: After reset the program counter, memory address register and accumulator are zero, the flags are zero=1, positive=0, negative=0, and halted, write-enable, input request and output valid are all low.
- R2: An instruction word is `ADDR_W+4` bits with the opcode in the top 4 bits. Fetch reads the word at the program counter, then increments the program counter by one (wrapping) before the instruction executes.
- R3: Opcode 1 (load) sets the accumulator to the memory word at the address field.
- R4: Opcode 2 (add) and opcode 4 (subtract) set the accumulator to the accumulator plus or minus the memory word at the address field, modulo 2^(ADDR_W+4).
- R5: Opcode 3 (store) writes the accumulator to the address field location in a single-cycle write pulse. The accumulator and flags are left unchanged.
- R6: Opcode 8 (jump) makes the address field the next fetch address.
- R7: Exactly one flag is set at any time. Zero means the accumulator is 0. Negative means its top bit is 1. Positive means neither holds. Flags change only after load, add, subtract and input.
- R8: Opcodes 9, 10 and 11 skip the next instruction when the zero, positive or negative flag, respectively, is set, and do nothing otherwise.
- R9: Opcode 5 (input) drives the address field on the device number output and holds the input request high until acknowledge. The accumulator then takes the input data.
- R10: Opcode 6 (output) raises output valid with the accumulator and the address field as device number. Valid, data and number are held stable until ready is seen.
- R11: Opcode 7 (halt) raises halted permanently. After that the core makes no memory writes and no device requests.
- R12: Opcodes 0 and 12 to 15 behave as halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | ADDR_W+4 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | ADDR_W+4 | Memory read data, one cycle after address |
| dev_num_o | output | ADDR_W | Device number of the current input/output instruction |
| dev_in_req_o | output | 1 | Input request |
| dev_in_ack_i | input | 1 | Input acknowledge, data valid |
| dev_in_data_i | input | ADDR_W+4 | Input data |
| dev_out_valid_o | output | 1 | Output data valid |
| dev_out_ready_i | input | 1 | Output accepted |
| dev_out_data_o | output | ADDR_W+4 | Output data (accumulator) |
| halted_o | output | 1 | Execution stopped |

## Verification
The bench builds the core with `ADDR_W = 6`, which gives 10-bit words and a 64-word memory that is reloaded in one cycle for every program. At that width the operand sweep for add and subtract covers the wrap points 511+1, 0-1 and 512-1 alongside spread values. Each run observes all three skip flags through stores that either happen or are skipped. Separate short programs exercise jumps, the device handshakes with delayed responses, flag retention across non-arithmetic instructions, and every undefined opcode.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'd2;
  localparam logic [OP_W-1:0] OPC_STORE = 4'd3;
  localparam logic [OP_W-1:0] OPC_SUB   = 4'd4;
  localparam logic [OP_W-1:0] OPC_IN    = 4'd5;
  localparam logic [OP_W-1:0] OPC_OUT   = 4'd6;
  localparam logic [OP_W-1:0] OPC_HALT  = 4'd7;
  localparam logic [OP_W-1:0] OPC_JMP   = 4'd8;
  localparam logic [OP_W-1:0] OPC_SKZ   = 4'd9;
  localparam logic [OP_W-1:0] OPC_SKG   = 4'd10;
  localparam logic [OP_W-1:0] OPC_SKL   = 4'd11;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} alu_op_e;
  typedef enum logic [1:0] {SK_ZERO, SK_POS, SK_NEG} skip_sel_e;
  typedef enum logic [2:0] {
    CL_MEMRD, CL_STORE, CL_IN, CL_OUT, CL_JMP, CL_SKIP, CL_HALT
  } class_e;

  typedef enum logic [3:0] {
    ST_F_MAR, ST_F_RD, ST_F_MDR, ST_F_IR, ST_F_INC, ST_DEC,
    ST_X_MAR, ST_X_RD, ST_X_MDR, ST_X_ALU,
    ST_S_MDR, ST_S_WR, ST_IO_IN, ST_IO_OUT, ST_HALT
  } state_e;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output class_e          cls_o,
  output alu_op_e         alu_op_o,
  output skip_sel_e       skip_sel_o
);
  always_comb begin
    cls_o      = CL_HALT;
    alu_op_o   = ALU_PASS;
    skip_sel_o = SK_ZERO;
    case (op_i)
      OPC_LOAD:  cls_o = CL_MEMRD;
      OPC_ADD:   begin cls_o = CL_MEMRD; alu_op_o = ALU_ADD; end
      OPC_SUB:   begin cls_o = CL_MEMRD; alu_op_o = ALU_SUB; end
      OPC_STORE: cls_o = CL_STORE;
      OPC_IN:    cls_o = CL_IN;
      OPC_OUT:   cls_o = CL_OUT;
      OPC_JMP:   cls_o = CL_JMP;
      OPC_SKZ:   begin cls_o = CL_SKIP; skip_sel_o = SK_ZERO; end
      OPC_SKG:   begin cls_o = CL_SKIP; skip_sel_o = SK_POS; end
      OPC_SKL:   begin cls_o = CL_SKIP; skip_sel_o = SK_NEG; end
      OPC_HALT:  cls_o = CL_HALT;
      default:   cls_o = CL_HALT;  // opcode 0 and 12..15
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  alu_op_e           op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] y_o,
  output logic              zero_o,
  output logic              pos_o,
  output logic              neg_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
  assign neg_o  = y_o[WORD_W-1];
  assign pos_o  = !zero_o && !neg_o;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int WORD_W = ADDR_W + OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] dev_num_o,
  output logic              dev_in_req_o,
  input  logic              dev_in_ack_i,
  input  logic [WORD_W-1:0] dev_in_data_i,
  output logic              dev_out_valid_o,
  input  logic              dev_out_ready_i,
  output logic [WORD_W-1:0] dev_out_data_o,
  output logic              halted_o
);
  state_e            state_q;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] mdr_q, ir_q, acc_q;
  logic              z_q, g_q, l_q;

  logic [OP_W-1:0]   ir_op;
  logic [ADDR_W-1:0] ir_addr;
  class_e            cls;
  alu_op_e           dec_alu_op, alu_op;
  skip_sel_e         skip_sel;
  logic [WORD_W-1:0] alu_b, alu_y;
  logic              alu_z, alu_g, alu_l, skip_hit;

  assign ir_op   = ir_q[WORD_W-1 -: OP_W];
  assign ir_addr = ir_q[ADDR_W-1:0];

  acc_decode u_dec (
    .op_i      (ir_op),
    .cls_o     (cls),
    .alu_op_o  (dec_alu_op),
    .skip_sel_o(skip_sel)
  );

  // IN reuses the ALU pass path so flags come from one place
  assign alu_op = (state_q == ST_IO_IN) ? ALU_PASS : dec_alu_op;
  assign alu_b  = (state_q == ST_IO_IN) ? dev_in_data_i : mdr_q;

  acc_alu #(.WORD_W(WORD_W)) u_alu (
    .op_i  (alu_op),
    .a_i   (acc_q),
    .b_i   (alu_b),
    .y_o   (alu_y),
    .zero_o(alu_z),
    .pos_o (alu_g),
    .neg_o (alu_l)
  );

  always_comb begin
    case (skip_sel)
      SK_POS:  skip_hit = g_q;
      SK_NEG:  skip_hit = l_q;
      default: skip_hit = z_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_F_MAR;
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      z_q     <= 1'b1;
      g_q     <= 1'b0;
      l_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_F_MAR: begin mar_q <= pc_q; state_q <= ST_F_RD; end
        ST_F_RD:  state_q <= ST_F_MDR;
        ST_F_MDR: begin mdr_q <= mem_rdata_i; state_q <= ST_F_IR; end
        ST_F_IR:  begin ir_q <= mdr_q; state_q <= ST_F_INC; end
        ST_F_INC: begin pc_q <= pc_q + ADDR_W'(1); state_q <= ST_DEC; end
        ST_DEC: begin
          case (cls)
            CL_MEMRD, CL_STORE: state_q <= ST_X_MAR;
            CL_IN:   state_q <= ST_IO_IN;
            CL_OUT:  state_q <= ST_IO_OUT;
            CL_JMP:  begin pc_q <= ir_addr; state_q <= ST_F_MAR; end
            CL_SKIP: begin
              if (skip_hit) pc_q <= pc_q + ADDR_W'(1);
              state_q <= ST_F_MAR;
            end
            default: state_q <= ST_HALT;
          endcase
        end
        ST_X_MAR: begin
          mar_q   <= ir_addr;
          state_q <= (cls == CL_STORE) ? ST_S_MDR : ST_X_RD;
        end
        ST_X_RD:  state_q <= ST_X_MDR;
        ST_X_MDR: begin mdr_q <= mem_rdata_i; state_q <= ST_X_ALU; end
        ST_X_ALU: begin
          acc_q <= alu_y;
          z_q <= alu_z; g_q <= alu_g; l_q <= alu_l;
          state_q <= ST_F_MAR;
        end
        ST_S_MDR: begin mdr_q <= acc_q; state_q <= ST_S_WR; end
        ST_S_WR:  state_q <= ST_F_MAR;
        ST_IO_IN: if (dev_in_ack_i) begin
          acc_q <= alu_y;
          z_q <= alu_z; g_q <= alu_g; l_q <= alu_l;
          state_q <= ST_F_MAR;
        end
        ST_IO_OUT: if (dev_out_ready_i) state_q <= ST_F_MAR;
        default:   state_q <= ST_HALT;
      endcase
    end
  end

  assign mem_addr_o      = mar_q;
  assign mem_wdata_o     = mdr_q;
  assign mem_we_o        = (state_q == ST_S_WR);
  assign dev_num_o       = ir_addr;
  assign dev_in_req_o    = (state_q == ST_IO_IN);
  assign dev_out_valid_o = (state_q == ST_IO_OUT);
  assign dev_out_data_o  = acc_q;
  assign halted_o        = (state_q == ST_HALT);

  AST_WRITE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R5
  AST_WRITE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == acc_q)); // R5
  AST_FLAG_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({z_q, g_q, l_q})); // R7
  AST_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_in_req_o && !dev_in_ack_i |=> dev_in_req_o); // R9
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_out_valid_o && !dev_out_ready_i |=>
      dev_out_valid_o && $stable(dev_out_data_o) && $stable(dev_num_o)); // R10
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o); // R11
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o && !dev_in_req_o && !dev_out_valid_o); // R11
endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;
  localparam int AW    = 6;
  localparam int WW    = AW + 4;
  localparam int DEPTH = 1 << AW;
  localparam int MASK  = (1 << WW) - 1;
  localparam int SENT  = 'h2AA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr, dev_num;
  logic [WW-1:0] mem_wdata, mem_rdata, in_data, out_data;
  logic          mem_we, in_req, in_ack, out_valid, out_rdy, halted;

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] img [DEPTH];
  int checks = 0, errors = 0;
  int wc, n_out, in_num;
  int out_num [4];
  int out_dat [4];
  int icnt, ocnt;

  always #5 clk = ~clk;

  acc_core #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata),
    .dev_num_o(dev_num), .dev_in_req_o(in_req), .dev_in_ack_i(in_ack),
    .dev_in_data_i(in_data), .dev_out_valid_o(out_valid),
    .dev_out_ready_i(out_rdy), .dev_out_data_o(out_data),
    .halted_o(halted)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= img[i];
    end else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      in_ack <= 1'b0; out_rdy <= 1'b0; icnt <= 0; ocnt <= 0;
      n_out <= 0; wc <= 0; in_num <= -1;
    end else begin
      if (mem_we) wc <= wc + 1;
      if (in_req && !in_ack) begin
        if (icnt == 2) begin in_ack <= 1'b1; in_num <= int'(dev_num); icnt <= 0; end
        else icnt <= icnt + 1;
      end else in_ack <= 1'b0;
      if (out_valid && !out_rdy) begin
        if (ocnt == 2) begin
          out_rdy <= 1'b1; ocnt <= 0;
          if (n_out < 4) begin
            out_num[n_out] <= int'(dev_num);
            out_dat[n_out] <= int'(out_data);
          end
          n_out <= n_out + 1;
        end else ocnt <= ocnt + 1;
      end else out_rdy <= 1'b0;
    end
  end

  function automatic logic [WW-1:0] enc(input int op, input int adr);
    return WW'((op << AW) | (adr & (DEPTH - 1)));
  endfunction

  function automatic int pick(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 511;
      3: return 512;
      4: return 1023;
      5: return 2;
      6: return 1022;
      default: return (i * 149 + 7) % 1024;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < DEPTH; i++) img[i] = WW'(SENT);
  endtask

  task automatic run();
    int n = 0;
    int w0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    check(halted, "R11 program reached halt", int'(halted), 1);
    w0 = wc;
    repeat (8) @(negedge clk);
    check(halted && wc == w0 && !in_req && !out_valid, "R11 halt is permanent and quiet",
          wc - w0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    in_data = '0;
    clear_img();
    @(negedge clk);
    // R1 reset state at the ports
    check(!halted && !mem_we && !in_req && !out_valid && mem_addr == '0,
          "R1 reset outputs", {halted, mem_we, in_req, out_valid}, 0);

    // R1 reset A=0 and Z=1: SKIPZ skips, G/L do not
    clear_img();
    img[0] = enc(9, 0); img[1] = enc(3, 42); img[2] = enc(3, 43);
    img[3] = enc(10, 0); img[4] = enc(3, 44); img[5] = enc(11, 0);
    img[6] = enc(3, 45); img[7] = enc(7, 0);
    run();
    check(mem[42] == WW'(SENT), "R1 R8 reset zero flag skip", int'(mem[42]), SENT);
    check(mem[43] == '0, "R1 reset accumulator zero", int'(mem[43]), 0);
    check(mem[44] == '0 && mem[45] == '0, "R1 R8 no positive/negative skip",
          int'(mem[44]) | int'(mem[45]), 0);

    // R3 R4 R7 R8 R2 operand sweep with wrap
    for (int ia = 0; ia < 20; ia++)
      for (int ib = 0; ib < 20; ib++)
        for (int sb = 0; sb < 2; sb++) begin
          int a = pick(ia), b = pick(ib), res;
          bit z, l, g;
          clear_img();
          img[0] = enc(1, 40); img[1] = enc(sb ? 4 : 2, 41); img[2] = enc(3, 42);
          img[3] = enc(9, 0);  img[4] = enc(3, 43);
          img[5] = enc(10, 0); img[6] = enc(3, 44);
          img[7] = enc(11, 0); img[8] = enc(3, 45); img[9] = enc(7, 0);
          img[40] = WW'(a); img[41] = WW'(b);
          run();
          res = (sb ? a - b : a + b) & MASK;
          z = (res == 0); l = ((res >> (WW - 1)) & 1) == 1; g = !z && !l;
          check(int'(mem[42]) == res, "R2 R3 R4 R5 add/sub result", int'(mem[42]), res);
          check(int'(mem[43]) == (z ? SENT : res), "R7 R8 zero skip", int'(mem[43]), z ? SENT : res);
          check(int'(mem[44]) == (g ? SENT : res), "R7 R8 positive skip", int'(mem[44]), g ? SENT : res);
          check(int'(mem[45]) == (l ? SENT : res), "R7 R8 negative skip", int'(mem[45]), l ? SENT : res);
        end

    // R6 jump, R7 flags kept across store/jump
    for (int v = 0; v < 2; v++) begin
      clear_img();
      img[0] = enc(1, 40); img[1] = enc(8, 4); img[2] = enc(3, 42); img[3] = enc(7, 0);
      img[4] = enc(3, 43); img[5] = enc(9, 0); img[6] = enc(3, 44); img[7] = enc(7, 0);
      img[40] = WW'(v ? 5 : 0);
      run();
      check(mem[42] == WW'(SENT), "R6 jump skips over", int'(mem[42]), SENT);
      check(int'(mem[43]) == (v ? 5 : 0), "R6 jump target runs", int'(mem[43]), v ? 5 : 0);
      check(int'(mem[44]) == (v ? 5 : SENT), "R7 flags held over store/jump",
            int'(mem[44]), v ? 5 : SENT);
    end

    // R9 R10 device handshakes, flags from IN
    for (int v = 0; v < 2; v++) begin
      clear_img();
      in_data = v ? WW'('h3F0) : WW'('h010);
      img[0] = enc(5, 5); img[1] = enc(3, 42); img[2] = enc(11, 0);
      img[3] = enc(6, 9); img[4] = enc(6, 7); img[5] = enc(7, 0);
      run();
      check(in_num == 5, "R9 input device number", in_num, 5);
      check(mem[42] == in_data, "R9 input data to accumulator", int'(mem[42]), int'(in_data));
      check(n_out == (v ? 1 : 2), "R7 R10 output count after IN flags", n_out, v ? 1 : 2);
      check(out_num[n_out-1] == 7 && out_dat[n_out-1] == int'(in_data),
            "R10 output number and data", out_dat[n_out-1], int'(in_data));
      if (!v) check(out_num[0] == 9, "R10 first output device", out_num[0], 9);
    end

    // R12 undefined opcodes halt
    for (int k = 0; k < 5; k++) begin
      int op = (k == 0) ? 0 : 11 + k;
      clear_img();
      img[0] = enc(op, 0); img[1] = enc(3, 42); img[2] = enc(7, 0);
      run();
      check(wc == 0 && mem[42] == WW'(SENT), "R12 undefined opcode halts", wc, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule